// File: doc/BRIEF.md
# Endian Mode Controller

This block holds the byte-order controls of a processor's bus path and applies the selected byte order to each access on its way to the external bus. Three kinds of control state are kept: a normal-mode little-endian bit and an exception-mode little-endian bit for the core, a cache-side endian-select bit, and a two-bit bus-ordering field. Together these select one of three modes. In big-endian mode the access passes through untouched. In true little-endian mode the address stays as issued and the data byte lanes are mirrored at the external bus. In processor-style little-endian mode the low address bits are flipped according to the access size and the data lanes are left alone.

When an exception is entered, the normal-mode bit is reloaded from the exception-mode bit, so the handler runs in the byte order chosen for it. Control writes change the state at the clock edge, so an access presented in the same cycle as a write is still steered with the old settings. Each access leaves the block one cycle later on registered outputs, together with the mode that was applied to it.

Top module: `endian_order_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, normal bit = 0, exception bit = 0, endian-select = 0, bus field = 2'b10, mode_o = 2'b00 (big-endian), cfg_illegal = 0 and bus_valid = 0. Writes, accesses and exception strobes during reset have no effect.
- R2: In big-endian mode, bus_addr equals the access address, bus_wdata equals the access data and lane enables follow the unmodified address.
- R3: Mode decode: normal bit 0, endian-select 0, bus field 1x gives mode_o = 2'b00 (big-endian). Normal bit 0, endian-select 1, bus field 1x gives 2'b01 (true little-endian). Normal bit 1, endian-select 0, bus field 01 gives 2'b10 (processor-style little-endian).
- R4: Any other combination of the three controls gives mode_o = 2'b00 with cfg_illegal = 1, and accesses are handled as big-endian.
- R5: On an exception-entry strobe the normal bit takes the value the exception bit held before that edge. This overrides a normal-bit write in the same cycle and ignores an exception-bit write in the same cycle.
- R6: In true little-endian mode the address is unchanged and data lane k moves to lane 3-k for every size. The lane enables are mirrored the same way.
- R7: In processor-style little-endian mode address bits [2:0] are XORed with 3'b111 for a byte, 3'b110 for a halfword and 3'b100 for a word. Data is unchanged and the lane enables follow the modified address.
- R8: An access presented in the same cycle as a control write or exception strobe uses the settings from before that edge. Its result appears on the bus outputs in the next cycle with bus_valid = 1, and mode_o reports the mode applied to it.
- R9: Size code 2'b00 is a byte, 2'b01 a halfword, 2'b10 a word, and 2'b11 is handled as a word. Lane k is data bits [31-8k:24-8k], and lane_en bit k enables lane k. Enabled lanes start at the address offset rounded down to the access size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_le_en | input | 1 | Write strobe for the normal-mode little-endian bit |
| wr_le_val | input | 1 | Value for the normal-mode bit |
| wr_ile_en | input | 1 | Write strobe for the exception-mode little-endian bit |
| wr_ile_val | input | 1 | Value for the exception-mode bit |
| wr_les_en | input | 1 | Write strobe for the endian-select bit |
| wr_les_val | input | 1 | Value for the endian-select bit |
| wr_bo_en | input | 1 | Write strobe for the bus-ordering field |
| wr_bo_val | input | 2 | Value for the bus-ordering field |
| exc_entry | input | 1 | Exception-entry strobe |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Core access address |
| acc_size | input | 2 | Access size code |
| acc_wdata | input | DATA_W | Access data, lane-aligned |
| bus_valid | output | 1 | Steered access present |
| bus_addr | output | ADDR_W | Steered address |
| bus_wdata | output | DATA_W | Steered data |
| bus_lane_en | output | DATA_W/8 | Byte-lane enables |
| mode_o | output | 2 | Mode applied to the current bus output |
| cfg_illegal | output | 1 | Control combination outside the decode table |
| le_o | output | 1 | Current normal-mode bit |
| ile_o | output | 1 | Current exception-mode bit |

## Verification
The interaction that needs the most care is an exception entry that lands in the same cycle as a write to either endian bit. That cycle decides whether the normal bit ends up with the copied value, the written value, or a value written to the exception bit in that same cycle. Directed sequences raise the strobe together with each kind of write. A random phase also lets these coincide with accesses, and a behavioural model that applies the priority order in the requirements judges every cycle. The same model also checks that an access issued alongside a write leaves with the mode from before the edge.

// File: rtl/endian_pkg.sv
package endian_pkg;

  typedef enum logic [1:0] {
    MODE_BE  = 2'b00,
    MODE_TLE = 2'b01,
    MODE_PLE = 2'b10
  } bo_mode_e;

  typedef struct packed {
    logic       le;
    logic       ile;
    logic       les;
    logic [1:0] bo;
  } endian_ctl_t;

  localparam logic [1:0] BO_RESET = 2'b10;

endpackage

// File: rtl/endian_ctl_regs.sv
module endian_ctl_regs
  import endian_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_le_en,
  input  logic        wr_le_val,
  input  logic        wr_ile_en,
  input  logic        wr_ile_val,
  input  logic        wr_les_en,
  input  logic        wr_les_val,
  input  logic        wr_bo_en,
  input  logic [1:0]  wr_bo_val,
  input  logic        exc_entry,
  output endian_ctl_t ctl
);

  endian_ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q.le  <= 1'b0;
      ctl_q.ile <= 1'b0;
      ctl_q.les <= 1'b0;
      ctl_q.bo  <= BO_RESET;
    end else begin
      // exception entry outranks a direct write of the normal bit
      if (exc_entry)     ctl_q.le  <= ctl_q.ile;
      else if (wr_le_en) ctl_q.le  <= wr_le_val;
      if (wr_ile_en)     ctl_q.ile <= wr_ile_val;
      if (wr_les_en)     ctl_q.les <= wr_les_val;
      if (wr_bo_en)      ctl_q.bo  <= wr_bo_val;
    end
  end

  assign ctl = ctl_q;

endmodule

// File: rtl/endian_mode_decode.sv
module endian_mode_decode
  import endian_pkg::*;
(
  input  endian_ctl_t ctl,
  output bo_mode_e    mode,
  output logic        illegal
);

  always_comb begin
    mode    = MODE_BE;
    illegal = 1'b0;
    if (!ctl.le && !ctl.les && ctl.bo[1]) begin
      mode = MODE_BE;
    end else if (!ctl.le && ctl.les && ctl.bo[1]) begin
      mode = MODE_TLE;
    end else if (ctl.le && !ctl.les && (ctl.bo == 2'b01)) begin
      mode = MODE_PLE;
    end else begin
      illegal = 1'b1;
    end
  end

endmodule

// File: rtl/endian_lane_steer.sv
module endian_lane_steer
  import endian_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  bo_mode_e                  mode,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic [1:0]                acc_size,
  input  logic [DATA_W-1:0]         acc_wdata,
  output logic [ADDR_W-1:0]         out_addr,
  output logic [DATA_W-1:0]         out_data,
  output logic [DATA_W/8-1:0]       out_lane_en
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int LSB_W = OFF_W + 1;

  logic [LSB_W-1:0]  flip;
  logic [ADDR_W-1:0] eff_addr;
  logic [LANES-1:0]  lane_lin;
  logic [LANES-1:0]  lane_rev;
  logic [DATA_W-1:0] data_rev;

  always_comb begin
    int slog;
    int nbytes;
    int base;
    slog   = (int'(acc_size) >= OFF_W) ? OFF_W : int'(acc_size);
    nbytes = 1 << slog;
    flip   = '0;
    if (mode == MODE_PLE) begin
      flip = LSB_W'(((1 << LSB_W) - 1) & ~(nbytes - 1));
    end
    eff_addr = acc_addr ^ {{(ADDR_W-LSB_W){1'b0}}, flip};
    base     = int'(eff_addr[OFF_W-1:0]) & ~(nbytes - 1);
    for (int k = 0; k < LANES; k++) begin
      lane_lin[k] = (k >= base) && (k < base + nbytes);
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_mirror
    assign data_rev[DATA_W-1-8*k -: 8] = acc_wdata[DATA_W-1-8*(LANES-1-k) -: 8];
    assign lane_rev[k]                 = lane_lin[LANES-1-k];
  end

  assign out_addr    = eff_addr;
  assign out_data    = (mode == MODE_TLE) ? data_rev : acc_wdata;
  assign out_lane_en = (mode == MODE_TLE) ? lane_rev : lane_lin;

endmodule

// File: rtl/endian_order_ctrl.sv
module endian_order_ctrl
  import endian_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_le_en,
  input  logic                wr_le_val,
  input  logic                wr_ile_en,
  input  logic                wr_ile_val,
  input  logic                wr_les_en,
  input  logic                wr_les_val,
  input  logic                wr_bo_en,
  input  logic [1:0]          wr_bo_val,
  input  logic                exc_entry,
  input  logic                acc_valid,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [1:0]          acc_size,
  input  logic [DATA_W-1:0]   acc_wdata,
  output logic                bus_valid,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W/8-1:0] bus_lane_en,
  output logic [1:0]          mode_o,
  output logic                cfg_illegal,
  output logic                le_o,
  output logic                ile_o
);

  localparam int LANES = DATA_W / 8;

  endian_ctl_t       ctl;
  bo_mode_e          mode_c;
  logic              illegal_c;
  logic [ADDR_W-1:0] addr_c;
  logic [DATA_W-1:0] data_c;
  logic [LANES-1:0]  lane_c;

  endian_ctl_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_le_en   (wr_le_en),
    .wr_le_val  (wr_le_val),
    .wr_ile_en  (wr_ile_en),
    .wr_ile_val (wr_ile_val),
    .wr_les_en  (wr_les_en),
    .wr_les_val (wr_les_val),
    .wr_bo_en   (wr_bo_en),
    .wr_bo_val  (wr_bo_val),
    .exc_entry  (exc_entry),
    .ctl        (ctl)
  );

  endian_mode_decode u_dec (
    .ctl     (ctl),
    .mode    (mode_c),
    .illegal (illegal_c)
  );

  endian_lane_steer #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_steer (
    .mode        (mode_c),
    .acc_addr    (acc_addr),
    .acc_size    (acc_size),
    .acc_wdata   (acc_wdata),
    .out_addr    (addr_c),
    .out_data    (data_c),
    .out_lane_en (lane_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid   <= 1'b0;
      bus_addr    <= '0;
      bus_wdata   <= '0;
      bus_lane_en <= '0;
      mode_o      <= MODE_BE;
      cfg_illegal <= 1'b0;
    end else begin
      bus_valid   <= acc_valid;
      mode_o      <= mode_c;
      cfg_illegal <= illegal_c;
      if (acc_valid) begin
        bus_addr    <= addr_c;
        bus_wdata   <= data_c;
        bus_lane_en <= lane_c;
      end
    end
  end

  assign le_o  = ctl.le;
  assign ile_o = ctl.ile;

endmodule

// File: rtl/endian_order_ctrl_chk.sv
module endian_order_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              exc_entry,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic              bus_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [1:0]        mode_o,
  input logic              cfg_illegal,
  input logic              le_o,
  input logic              ile_o
);

  localparam int LSB_W = $clog2(DATA_W / 8) + 1;

  assert_reset_be_R1: assert property (@(posedge clk)
    $past(rst) |-> (mode_o == 2'b00 && !cfg_illegal && !bus_valid && !le_o && !ile_o));

  assert_be_passthru_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && mode_o == 2'b00 && !$past(rst))
      |-> (bus_addr == $past(acc_addr) && bus_wdata == $past(acc_wdata)));

  assert_illegal_forces_be_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_illegal |-> mode_o == 2'b00);

  assert_exc_copy_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(exc_entry)) |-> le_o == $past(ile_o));

  assert_tle_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && mode_o == 2'b01 && !$past(rst)) |-> bus_addr == $past(acc_addr));

  assert_ple_data_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && mode_o == 2'b10 && !$past(rst))
      |-> (bus_wdata == $past(acc_wdata)
           && bus_addr[ADDR_W-1:LSB_W] == $past(acc_addr[ADDR_W-1:LSB_W])));

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> bus_valid == $past(acc_valid));

endmodule

bind endian_order_ctrl endian_order_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .exc_entry   (exc_entry),
  .acc_valid   (acc_valid),
  .acc_addr    (acc_addr),
  .acc_wdata   (acc_wdata),
  .bus_valid   (bus_valid),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .mode_o      (mode_o),
  .cfg_illegal (cfg_illegal),
  .le_o        (le_o),
  .ile_o       (ile_o)
);

// File: tb/endian_order_ctrl_test.sv
module endian_order_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_le_en = 0, wr_le_val = 0, wr_ile_en = 0, wr_ile_val = 0;
  logic        wr_les_en = 0, wr_les_val = 0, wr_bo_en = 0;
  logic [1:0]  wr_bo_val = 0;
  logic        exc_entry = 0, acc_valid = 0;
  logic [31:0] acc_addr = 0;
  logic [1:0]  acc_size = 0;
  logic [31:0] acc_wdata = 0;
  logic        bus_valid;
  logic [31:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_lane_en;
  logic [1:0]  mode_o;
  logic        cfg_illegal, le_o, ile_o;

  always #5 clk = ~clk;

  endian_order_ctrl uut (
    .clk(clk), .rst(rst),
    .wr_le_en(wr_le_en), .wr_le_val(wr_le_val),
    .wr_ile_en(wr_ile_en), .wr_ile_val(wr_ile_val),
    .wr_les_en(wr_les_en), .wr_les_val(wr_les_val),
    .wr_bo_en(wr_bo_en), .wr_bo_val(wr_bo_val),
    .exc_entry(exc_entry), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_lane_en(bus_lane_en), .mode_o(mode_o), .cfg_illegal(cfg_illegal),
    .le_o(le_o), .ile_o(ile_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference state
  int m_le = 0, m_ile = 0, m_les = 0, m_bo = 2;
  int e_valid, e_mode, e_ill, e_le, e_ile;
  longint e_addr, e_data, e_be;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_eval();
    int mode, ill, nb, off, a;
    longint d, be;
    if (rst) begin
      m_le = 0; m_ile = 0; m_les = 0; m_bo = 2;
      e_valid = 0; e_mode = 0; e_ill = 0; e_le = 0; e_ile = 0;
      return;
    end
    ill = 0;
    if (m_le == 0 && m_les == 0 && m_bo >= 2)       mode = 0;
    else if (m_le == 0 && m_les == 1 && m_bo >= 2)  mode = 1;
    else if (m_le == 1 && m_les == 0 && m_bo == 1)  mode = 2;
    else begin mode = 0; ill = 1; end
    e_mode = mode; e_ill = ill; e_valid = acc_valid;
    if (acc_valid) begin
      nb = (acc_size == 0) ? 1 : (acc_size == 1) ? 2 : 4;
      a = int'(acc_addr);
      if (mode == 2) a = a ^ ((nb == 1) ? 7 : (nb == 2) ? 6 : 4);
      off = ((a & 3) / nb) * nb;
      be = ((longint'(1) << nb) - 1) << off;
      d = longint'(acc_wdata);
      if (mode == 1) begin
        d = ((d & 'hFF) << 24) | ((d & 'hFF00) << 8) | ((d >> 8) & 'hFF00) | ((d >> 24) & 'hFF);
        be = ((be & 1) << 3) | ((be & 2) << 1) | ((be & 4) >> 1) | ((be & 8) >> 3);
      end
      e_addr = longint'(unsigned'(a));
      e_data = d;
      e_be = be;
    end
    begin
      int old_ile = m_ile;
      if (exc_entry)      m_le = old_ile;
      else if (wr_le_en)  m_le = wr_le_val;
      if (wr_ile_en) m_ile = wr_ile_val;
      if (wr_les_en) m_les = wr_les_val;
      if (wr_bo_en)  m_bo = wr_bo_val;
    end
    e_le = m_le; e_ile = m_ile;
  endtask

  task automatic compare(string phase);
    string breq;
    breq = (e_mode == 1) ? "R6" : (e_mode == 2) ? "R7" : "R2";
    chk(e_ill ? "R4" : "R3", {phase, " mode_o"}, mode_o, e_mode);
    chk("R4", {phase, " cfg_illegal"}, cfg_illegal, e_ill);
    chk("R5", {phase, " le_o"}, le_o, e_le);
    chk("R5", {phase, " ile_o"}, ile_o, e_ile);
    chk("R8", {phase, " bus_valid"}, bus_valid, e_valid);
    if (e_valid) begin
      chk(breq, {phase, " bus_addr"}, bus_addr, e_addr);
      chk(breq, {phase, " bus_wdata"}, bus_wdata, e_data);
      chk("R9", {phase, " bus_lane_en"}, bus_lane_en, e_be);
    end
  endtask

  task automatic tick(string phase);
    model_eval();
    @(negedge clk);
    compare(phase);
  endtask

  task automatic idle();
    wr_le_en = 0; wr_ile_en = 0; wr_les_en = 0; wr_bo_en = 0;
    exc_entry = 0; acc_valid = 0;
  endtask

  task automatic access(logic [31:0] a, logic [1:0] s, logic [31:0] d);
    acc_valid = 1; acc_addr = a; acc_size = s; acc_wdata = d;
  endtask

  task automatic sweep(string phase);
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 8; o += (s == 0) ? 1 : (s == 1) ? 2 : 4) begin
        idle(); access(32'h0000_4000 + o, 2'(s), 32'hA1B2_C3D4 + o);
        tick(phase);
      end
    end
    idle(); tick(phase);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset with traffic and writes that must be ignored
    rst = 1;
    wr_le_en = 1; wr_le_val = 1; wr_ile_en = 1; wr_ile_val = 1;
    wr_les_en = 1; wr_les_val = 1; wr_bo_en = 1; wr_bo_val = 2'b00;
    exc_entry = 1; access(32'h10, 2'b10, 32'h1122_3344);
    tick("R1 reset"); tick("R1 reset");
    rst = 0; idle(); tick("R1 after reset");

    // R2 / R9: big-endian sweep over all sizes and offsets
    sweep("R2 R9 be");

    // R3 / R6: select true little-endian
    idle(); wr_les_en = 1; wr_les_val = 1; tick("R3 set tle");
    sweep("R6 tle");

    // R3 / R7: processor-style little-endian
    idle(); wr_les_en = 1; wr_les_val = 0; wr_le_en = 1; wr_le_val = 1;
    wr_bo_en = 1; wr_bo_val = 2'b01; tick("R3 set ple");
    sweep("R7 ple");

    // R4: unlisted combinations
    idle(); wr_bo_en = 1; wr_bo_val = 2'b00; tick("R4 set");
    sweep("R4 illegal");
    idle(); wr_le_en = 1; wr_le_val = 0; wr_bo_en = 1; wr_bo_val = 2'b01; tick("R4 set");
    idle(); access(32'h22, 2'b00, 32'hDEAD_BEEF); tick("R4 illegal");
    idle(); wr_bo_en = 1; wr_bo_val = 2'b11; tick("R4 back");
    idle(); tick("R4 back");

    // R5: exception copy, and same-cycle interactions
    idle(); wr_ile_en = 1; wr_ile_val = 1; wr_bo_en = 1; wr_bo_val = 2'b01; tick("R5 setup");
    idle(); exc_entry = 1; wr_le_en = 1; wr_le_val = 0; tick("R5 exc beats le write");
    idle(); access(32'h31, 2'b00, 32'h0102_0304); tick("R5 handler ple");
    idle(); wr_le_en = 1; wr_le_val = 0; tick("R5 clear");
    idle(); exc_entry = 1; wr_ile_en = 1; wr_ile_val = 0; tick("R5 exc with ile write");
    idle(); exc_entry = 1; tick("R5 exc copies zero");
    idle(); wr_bo_en = 1; wr_bo_val = 2'b10; tick("R5 restore");

    // R8: write and access in the same cycle use old settings
    idle(); wr_les_en = 1; wr_les_val = 1; access(32'h40, 2'b10, 32'hCAFE_F00D);
    tick("R8 write with access");
    idle(); access(32'h40, 2'b10, 32'hCAFE_F00D); tick("R8 next access");
    idle(); wr_les_en = 1; wr_les_val = 0; access(32'h41, 2'b00, 32'h5566_7788);
    tick("R8 write with access");
    idle(); access(32'h42, 2'b01, 32'h5566_7788); tick("R8 next access");

    // random mix of writes, exceptions and accesses
    for (int i = 0; i < 3000; i++) begin
      idle();
      wr_le_en  = ($urandom_range(0, 9) == 0); wr_le_val  = 1'($urandom);
      wr_ile_en = ($urandom_range(0, 9) == 0); wr_ile_val = 1'($urandom);
      wr_les_en = ($urandom_range(0, 9) == 0); wr_les_val = 1'($urandom);
      wr_bo_en  = ($urandom_range(0, 9) == 0); wr_bo_val  = 2'($urandom);
      exc_entry = ($urandom_range(0, 11) == 0);
      acc_valid = ($urandom_range(0, 3) != 0);
      acc_addr  = $urandom; acc_size = 2'($urandom); acc_wdata = $urandom;
      tick("random");
    end

    // reset again mid-run
    idle(); rst = 1; tick("R1 second reset");
    rst = 0; tick("R1 after second reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule